// File: doc/BRIEF.md
# Page Write Collector and Program Sequencer

This block sits behind the serial front end of a byte-addressed non-volatile memory model. Once the command decoder has accepted a write command and its start address, the block collects the data bytes that follow into a page buffer. The buffer holds as many bytes as a page, 32 by default. The buffer index begins at the low bits of the start address and steps by one per byte. Only those low bits move, so a stream longer than a page wraps around and overwrites the bytes it stored earlier. The upper address bits never change.

When chip select rises, the block checks three things: the write-enable latch was set when the command arrived, the last byte was complete, and at least one byte was received. If all three hold, it scans the page once, in ascending index order, at one entry per clock. During the scan it issues an array write for each entry that received data and that the protection logic permits. It then stays busy for a parameterised number of clocks to stand in for the self-timed program cycle. At the end it pulses a done flag, which the surrounding logic uses to clear the write-enable latch. If any of the three conditions fails, the transaction is dropped and the block returns to idle without writing anything. No erase step comes before the writes.

Top module: `page_program_seq`

## Requirements
- R1: After reset `busy`, `mem_we` and `wr_done` are all 0.
- R2: The first data byte goes to page index = low `PAGE_BITS` bits of `wr_addr`. Each later byte goes to the next index. During the commit, `mem_addr` is {upper bits of `wr_addr`, index}, so the upper bits never change.
- R3: If more than `PAGE_BYTES` bytes arrive, the index wraps modulo `PAGE_BYTES`, and the last byte sent to an index is the one written.
- R4: If `cs_rise` arrives with `byte_whole` = 0, the whole transaction is discarded: no `mem_we`, and `busy` stays 0.
- R5: If `wel` = 0 when `wr_start` is accepted, the transaction writes nothing, never raises `busy`, and the block is idle again after `cs_rise`.
- R6: The commit issues `mem_we` only for indices that received data, one per cycle, in strictly ascending address order.
- R7: An entry whose address has `mem_permit` = 0 during its commit cycle is dropped. The other entries are still written.
- R8: `busy` rises in the cycle after the accepted `cs_rise` and stays high for exactly `PAGE_BYTES + WRITE_CYCLES` cycles. `wr_done` is then high for exactly one cycle, the first cycle with `busy` low.
- R9: While `busy` is high, `wr_start`, `byte_valid` and `cs_rise` are ignored: no extra writes, no change to the busy length, no second `wr_done`.
- R10: A `cs_rise` with `byte_whole` = 1 but no data byte received starts no commit, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Write command accepted; latch the start address |
| wr_addr | input | ADDR_W | Start address of the write |
| wel | input | 1 | Write-enable latch state |
| byte_valid | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has risen (end of transaction) |
| byte_whole | input | 1 | 1 if the last byte before `cs_rise` was complete |
| mem_permit | input | 1 | 1 if `mem_addr` may be written |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit scan or program cycle in progress |
| wr_done | output | 1 | One-cycle pulse when the program cycle ends; clears the write-enable latch |

## Verification
The bench drives each stimulus on a falling edge, so the block takes it at the next rising edge. `busy` is therefore visible at the following falling edge. The scan and the program cycle last `PAGE_BYTES + WRITE_CYCLES` cycles. `wr_done` appears in the first cycle with `busy` low, so each scenario waits for `busy` to fall and then two more falling edges before it checks results. Array writes are logged at every rising edge with `mem_we` high, and busy cycles and done pulses are counted the same way. The length checks therefore compare exact cycle counts instead of sampling a single instant.

// File: rtl/page_program_pkg.sv
package page_program_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int PAGE_BYTES = 32,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] ridx,
    output logic [7:0]    rdata,
    output logic          rvalid,
    output logic          any_valid
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0]      mask;
        logic [PAGE_BYTES-1:0][7:0] data;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.mask = '0;
        end else if (we) begin
            buf_d.mask[widx] = 1'b1;
            buf_d.data[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rdata     = buf_q.data[ridx];
    assign rvalid    = buf_q.mask[ridx];
    assign any_valid = |buf_q.mask;

    // R6: a clear leaves no entry marked as received
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);
endmodule

// File: rtl/program_timer.sv
module program_timer #(
    parameter int CYCLES = 1000,
    localparam int TW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = TW'(CYCLES - 1);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R8: a load always starts a countdown from the configured length
    a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == TW'(CYCLES - 1)));
endmodule

// File: rtl/page_program_seq.sv
module page_program_seq
    import page_program_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 1000,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wel,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              byte_whole,
    input  logic              mem_permit,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              wr_done
);
    typedef struct packed {
        seq_state_e           st;
        logic [ADDR_W-PW-1:0] page;
        logic [PW-1:0]        ptr;
        logic [PW-1:0]        idx;
        logic                 en;
        logic                 done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic       buf_clr, buf_we, buf_rvalid, buf_any;
    logic [7:0] buf_rdata;
    logic       tmr_load, tmr_expired;

    page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .we        (buf_we),
        .widx      (seq_q.ptr),
        .wdata     (byte_data),
        .ridx      (seq_q.idx),
        .rdata     (buf_rdata),
        .rvalid    (buf_rvalid),
        .any_valid (buf_any)
    );

    program_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        buf_clr    = 1'b0;
        buf_we     = 1'b0;
        tmr_load   = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (wr_start) begin
                    seq_d.st   = ST_FILL;
                    seq_d.page = wr_addr[ADDR_W-1:PW];
                    seq_d.ptr  = wr_addr[PW-1:0];
                    seq_d.en   = wel;
                    buf_clr    = 1'b1;
                end
            end
            ST_FILL: begin
                if (byte_valid && seq_q.en) begin
                    buf_we    = 1'b1;
                    seq_d.ptr = seq_q.ptr + 1'b1;
                end
                if (cs_rise) begin
                    if (seq_q.en && byte_whole && buf_any) begin
                        seq_d.st  = ST_COMMIT;
                        seq_d.idx = '0;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            ST_COMMIT: begin
                seq_d.idx = seq_q.idx + 1'b1;
                if (seq_q.idx == PW'(PAGE_BYTES - 1)) begin
                    seq_d.st = ST_HOLD;
                    tmr_load = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign mem_we    = (seq_q.st == ST_COMMIT) && buf_rvalid && mem_permit;
    assign mem_addr  = {seq_q.page, seq_q.idx};
    assign mem_wdata = buf_rdata;
    assign busy      = (seq_q.st == ST_COMMIT) || (seq_q.st == ST_HOLD);
    assign wr_done   = seq_q.done;

    // R7: no array write to a location the protection logic refuses
    a_r7_permit_respected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_permit);

    // R9: array writes happen only inside a busy window
    a_r9_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    // R2: the page part of the address is constant through a commit scan
    a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_COMMIT && $past(seq_q.st == ST_COMMIT))
            |-> $stable(mem_addr[ADDR_W-1:PW]));

    // R4: an incomplete final byte never leads to busy
    a_r4_partial_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_FILL && cs_rise && !byte_whole) |=> !busy);

    // R5: a command without write enable returns to idle on chip select rise
    a_r5_no_enable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_FILL && !seq_q.en && cs_rise) |=> (seq_q.st == ST_IDLE));

    // R8: done is a single pulse that directly follows busy
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ($past(busy) && !busy));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R9: the program hold cannot be cut short by bus activity
    a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_HOLD && !tmr_expired) |=> (seq_q.st == ST_HOLD));
endmodule

// File: tb/page_program_seq_bench.sv
module page_program_seq_bench;
    localparam int AW   = 13;
    localparam int PB   = 32;
    localparam int WC   = 20;
    localparam int BUSY_LEN = PB + WC;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_start = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wel = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cs_rise = 1'b0;
    logic          byte_whole = 1'b0;
    logic          mem_permit;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          busy;
    logic          wr_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic          prot_on = 1'b0;
    logic [AW-1:0] prot_a = '0;
    logic [AW-1:0] prot_b = '0;
    assign mem_permit = !(prot_on && (mem_addr == prot_a || mem_addr == prot_b));

    always #5 clk = ~clk;

    page_program_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u_page_program_seq (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr), .wel(wel),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .byte_whole(byte_whole), .mem_permit(mem_permit), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .wr_done(wr_done)
    );

    logic [7:0] amem [DEPTH];
    bit         hit  [DEPTH];
    int writes, busy_cycles, done_cnt, order_err, last_addr;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                amem[mem_addr] = mem_wdata;
                hit[mem_addr]  = 1'b1;
                writes++;
                if (int'(mem_addr) <= last_addr) order_err++;
                last_addr = int'(mem_addr);
            end
            if (!busy) last_addr = -1;
            if (busy) busy_cycles++;
            if (wr_done) done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < DEPTH; i++) hit[i] = 1'b0;
        writes = 0; busy_cycles = 0; done_cnt = 0; order_err = 0; last_addr = -1;
    endtask

    task automatic start_cmd(input logic [AW-1:0] a, input logic en);
        @(negedge clk);
        wr_start = 1'b1; wr_addr = a; wel = en;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic rise(input logic whole);
        @(negedge clk);
        cs_rise = 1'b1; byte_whole = whole;
        @(negedge clk);
        cs_rise = 1'b0; byte_whole = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0,    "R1 busy after reset", busy, 0);
        chk(mem_we == 1'b0,  "R1 mem_we after reset", mem_we, 0);
        chk(wr_done == 1'b0, "R1 wr_done after reset", wr_done, 0);
    endtask

    task automatic t_basic();
        clear_log();
        start_cmd(13'h0123, 1'b1);
        send(8'hA1); send(8'hB2); send(8'hC3);
        rise(1'b1);
        wait_idle();
        chk(writes == 3, "R6 basic write count", writes, 3);
        chk(hit[13'h0123] && amem[13'h0123] == 8'hA1, "R2 byte0 at start", amem[13'h0123], 8'hA1);
        chk(hit[13'h0125] && amem[13'h0125] == 8'hC3, "R2 byte2 at start+2", amem[13'h0125], 8'hC3);
        chk(!hit[13'h0122] && !hit[13'h0126], "R6 unreceived entries untouched", writes, 3);
        chk(busy_cycles == BUSY_LEN, "R8 busy length", busy_cycles, BUSY_LEN);
        chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        chk(order_err == 0, "R6 ascending order", order_err, 0);
    endtask

    task automatic t_wrap();
        logic [7:0] exp [PB];
        int outside;
        clear_log();
        start_cmd(13'h0A1E, 1'b1);
        for (int k = 0; k < 34; k++) begin
            exp[(30 + k) % PB] = 8'(8'h40 + k);
            send(8'(8'h40 + k));
        end
        rise(1'b1);
        wait_idle();
        chk(writes == PB, "R3 full page written once", writes, PB);
        chk(amem[13'h0A1E] == 8'h60, "R3 index 30 overwritten", amem[13'h0A1E], 8'h60);
        chk(amem[13'h0A1F] == 8'h61, "R3 index 31 overwritten", amem[13'h0A1F], 8'h61);
        chk(amem[13'h0A00] == exp[0], "R2 wrap to page base", amem[13'h0A00], exp[0]);
        outside = 0;
        for (int i = 0; i < DEPTH; i++)
            if (hit[i] && (i[AW-1:5] != 8'h50)) outside++;
        chk(outside == 0, "R2 upper bits fixed", outside, 0);
        chk(order_err == 0, "R6 ascending order wrap", order_err, 0);
    endtask

    task automatic t_partial();
        clear_log();
        start_cmd(13'h0300, 1'b1);
        send(8'h11); send(8'h22);
        rise(1'b0);
        wait_idle();
        chk(writes == 0, "R4 partial byte writes", writes, 0);
        chk(busy_cycles == 0, "R4 partial byte busy", busy_cycles, 0);
    endtask

    task automatic t_no_wel();
        clear_log();
        start_cmd(13'h0400, 1'b0);
        send(8'h33);
        rise(1'b1);
        wait_idle();
        chk(writes == 0, "R5 no enable writes", writes, 0);
        chk(busy_cycles == 0, "R5 no enable busy", busy_cycles, 0);
        start_cmd(13'h0410, 1'b1);
        send(8'h44);
        rise(1'b1);
        wait_idle();
        chk(writes == 1 && amem[13'h0410] == 8'h44, "R5 idle again after ignore", writes, 1);
    endtask

    task automatic t_protect();
        clear_log();
        prot_on = 1'b1; prot_a = 13'h1803; prot_b = 13'h1805;
        start_cmd(13'h1802, 1'b1);
        send(8'h51); send(8'h52); send(8'h53); send(8'h54);
        rise(1'b1);
        wait_idle();
        prot_on = 1'b0;
        chk(writes == 2, "R7 only permitted written", writes, 2);
        chk(!hit[13'h1803] && !hit[13'h1805], "R7 protected dropped", writes, 2);
        chk(hit[13'h1804] && amem[13'h1804] == 8'h53, "R7 permitted neighbour", amem[13'h1804], 8'h53);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        start_cmd(13'h0500, 1'b1);
        send(8'h66);
        rise(1'b1);
        start_cmd(13'h0600, 1'b1);
        send(8'h77);
        rise(1'b1);
        send(8'h78);
        wait_idle();
        chk(writes == 1, "R9 writes during busy", writes, 1);
        chk(busy_cycles == BUSY_LEN, "R9 busy length unchanged", busy_cycles, BUSY_LEN);
        chk(done_cnt == 1, "R9 one done", done_cnt, 1);
        chk(!hit[13'h0600], "R9 second command ignored", hit[13'h0600], 0);
    endtask

    task automatic t_empty();
        clear_log();
        start_cmd(13'h0700, 1'b1);
        rise(1'b1);
        wait_idle();
        chk(busy_cycles == 0, "R10 empty transaction busy", busy_cycles, 0);
        chk(writes == 0, "R10 empty transaction writes", writes, 0);
    endtask

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_partial();
        t_no_wel();
        t_protect();
        t_busy_ignore();
        t_empty();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule